// File: doc/BRIEF.md
# Word Buffer Translation Controller

This block sits between a byte receiver and a text-to-cell rule-matching engine. It gathers printable characters into a word buffer. A space marks the end of a word, and the controller then walks through the buffered word one entry point at a time. At each entry point it shows the engine the character there, the whole buffered word and its length. The engine answers with how many characters its rule used up and with zero to four six-dot cells. The controller steps ahead by that count and stops once it reaches the end of the word.

The cells from all rules of the word go into an output queue. The queue is then drained through a valid/ready handshake. After the last cell leaves, the buffer is cleared and collection starts again. The block accepts no characters while it translates or drains. A word that grows past the buffer capacity is cut short and translated at once, and a one-cycle flag reports this. A space that arrives with an empty buffer becomes a single blank cell, and the engine is not used.

Top module: `wordbuf_xlate_ctrl`

## Requirements
- R1: When `rx_accept` is high, each one-cycle `rx_strobe` carrying a non-space character appends that character at the end of the word buffer, and `eng_len` counts up by one.
- R2: The buffer holds 40 characters. A non-space strobe that arrives with 40 characters already buffered is dropped and starts translation of those 40. `overflow` is high for exactly one cycle, the cycle after that strobe.
- R3: A space (8'h20) that arrives with a non-empty buffer starts translation at position 0.
- R4: While `eng_req` is high, `eng_entry` equals the buffered character at `eng_pos`. `eng_word` shows the whole buffer, with character i at bits [8i+7:8i], and `eng_len` gives its length.
- R5: On `eng_done`, the position moves ahead by `eng_consumed`, and a value of 0 counts as 1. Translation ends when the position reaches or passes the word length, so no request is made past the end.
- R6: On `eng_done`, the first `eng_ncodes` cells of `eng_codes` are appended to the output queue in order. Cell k sits at bits [6k+5:6k].
- R7: The output queue holds 64 cells. Cells pushed once it is full are discarded.
- R8: `out_valid` presents the queued cells in order. While `out_ready` is low, `out_valid` stays high and `out_cell` does not change. After the last cell is taken, `rx_accept` returns high and `eng_len` is 0.
- R9: Strobes that arrive while `rx_accept` is low are ignored.
- R10: A space that arrives with an empty buffer queues a single blank cell (6'b000000), and `eng_req` is never raised for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_char | input | 8 | Received character |
| rx_strobe | input | 1 | One-cycle new-character strobe |
| rx_accept | output | 1 | High while characters are being collected |
| eng_req | output | 1 | Rule-match request for the current entry point |
| eng_pos | output | 6 | Current position in the word |
| eng_entry | output | 8 | Character at the current position |
| eng_word | output | 320 | Whole buffered word, character i at [8i+7:8i] |
| eng_len | output | 6 | Number of buffered characters |
| eng_done | input | 1 | Engine result valid for the current request |
| eng_consumed | input | 6 | Characters used up by the matched rule |
| eng_ncodes | input | 3 | Number of cells in eng_codes (0 to 4) |
| eng_codes | input | 24 | Result cells, cell k at [6k+5:6k] |
| out_valid | output | 1 | Output cell valid |
| out_cell | output | 6 | Six-dot output cell |
| out_ready | input | 1 | Sink accepts out_cell |
| overflow | output | 1 | One-cycle pulse when a word is cut at capacity |

## Verification
The bench checks that a two-character rule makes the controller skip the second character. A design that steps by one would request an extra rule and emit an extra cell. A zero consumed count has to step by one, otherwise the controller hangs, and a count that runs past the end has to stop translation instead of reading stale buffer slots. Four edge cases are covered. A 41-character word must produce exactly 40 cells and a single overflow pulse. A word that yields 80 cells must be trimmed to 64 and must not wrap over the start of the queue. A strobe sent while the queue is draining must not leak into the next word. A lone space must produce a blank cell without an engine request.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

    localparam int          CHAR_W     = 8;
    localparam int          CELL_W     = 6;
    localparam logic [7:0]  SPACE_CHAR = 8'h20;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_XLATE,
        ST_EMIT
    } wbx_state_e;

    // Per-cycle control strobes from the sequencer to the storage blocks
    typedef struct packed {
        logic buf_wr;      // append incoming character
        logic push_space;  // queue one blank cell
        logic push_rule;   // queue engine result cells
        logic clear;       // empty buffer and queue
    } wbx_ctl_t;

endpackage

// File: rtl/wbx_word_buf.sv
module wbx_word_buf #(
    parameter int MAX_CHARS = 40,
    parameter int CHAR_W    = 8,
    parameter int POS_W     = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [CHAR_W-1:0]           wr_char,
    input  logic                        clr,
    output logic [POS_W-1:0]            len,
    output logic [MAX_CHARS*CHAR_W-1:0] word
);

    localparam logic [POS_W-1:0] FULL = POS_W'(MAX_CHARS);

    always_ff @(posedge clk) begin
        if (rst || clr)
            len <= '0;
        else if (wr_en && len < FULL)
            len <= len + 1'b1;
    end

    for (genvar i = 0; i < MAX_CHARS; i++) begin : g_slot
        logic [CHAR_W-1:0] slot;
        always_ff @(posedge clk) begin
            if (rst)
                slot <= '0;
            else if (wr_en && len == POS_W'(i))
                slot <= wr_char;
        end
        assign word[i*CHAR_W +: CHAR_W] = slot;
    end

    AST_BUF_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> len < FULL);  // R2
    AST_BUF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> len == '0);     // R8

endmodule

// File: rtl/wbx_cell_queue.sv
module wbx_cell_queue #(
    parameter int DEPTH  = 64,
    parameter int CELL_W = 6,
    parameter int CPR    = 4,
    parameter int CNT_W  = 7,
    parameter int NC_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  push_en,
    input  logic [NC_W-1:0]       push_n,
    input  logic [CPR*CELL_W-1:0] push_cells,
    input  logic                  pop,
    output logic [CELL_W-1:0]     head,
    output logic                  empty
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [CELL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  wr_cnt;
    logic [CNT_W-1:0]  rd_idx;
    logic [CNT_W:0]    wr_sum [CPR];
    logic              wr_ok  [CPR];
    logic [CNT_W:0]    total;

    always_comb begin
        for (int k = 0; k < CPR; k++) begin
            wr_sum[k] = {1'b0, wr_cnt} + (CNT_W+1)'(k);
            wr_ok[k]  = push_en && (NC_W'(k) < push_n) &&
                        (wr_sum[k] < (CNT_W+1)'(DEPTH));
        end
        total = {1'b0, wr_cnt} + (CNT_W+1)'(push_n);
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < CPR; k++)
            if (wr_ok[k])
                mem[wr_sum[k][IDX_W-1:0]] <= push_cells[k*CELL_W +: CELL_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_cnt <= '0;
            rd_idx <= '0;
        end else begin
            if (push_en)
                wr_cnt <= (total > (CNT_W+1)'(DEPTH)) ? CNT_W'(DEPTH)
                                                      : total[CNT_W-1:0];
            if (pop && !empty)
                rd_idx <= rd_idx + 1'b1;
        end
    end

    assign empty = (rd_idx == wr_cnt);
    assign head  = mem[rd_idx[IDX_W-1:0]];

    AST_QUEUE_CAP: assert property (@(posedge clk) disable iff (rst)
        wr_cnt <= CNT_W'(DEPTH));  // R7
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);           // R8

endmodule

// File: rtl/wbx_sequencer.sv
module wbx_sequencer
    import wbx_pkg::*;
#(
    parameter int MAX_CHARS = 40,
    parameter int POS_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_strobe,
    input  logic [7:0]        rx_char,
    input  logic [POS_W-1:0]  len,
    input  logic              eng_done,
    input  logic [POS_W-1:0]  eng_consumed,
    input  logic              q_empty,
    output wbx_ctl_t          ctl,
    output logic [POS_W-1:0]  pos,
    output logic              eng_req,
    output logic              accepting,
    output logic              emitting,
    output logic              overflow
);

    wbx_state_e        state, state_n;
    logic [POS_W-1:0]  pos_n, step;
    logic [POS_W:0]    adv;
    logic              ovf_n;

    always_comb begin
        state_n = state;
        pos_n   = pos;
        ctl     = '0;
        ovf_n   = 1'b0;
        eng_req = 1'b0;
        step    = (eng_consumed == '0) ? POS_W'(1) : eng_consumed;
        adv     = {1'b0, pos} + {1'b0, step};
        unique case (state)
            ST_COLLECT: if (rx_strobe) begin
                if (rx_char == SPACE_CHAR) begin
                    if (len == '0) begin
                        ctl.push_space = 1'b1;
                        state_n        = ST_EMIT;
                    end else begin
                        pos_n   = '0;
                        state_n = ST_XLATE;
                    end
                end else if (len == POS_W'(MAX_CHARS)) begin
                    ovf_n   = 1'b1;
                    pos_n   = '0;
                    state_n = ST_XLATE;
                end else begin
                    ctl.buf_wr = 1'b1;
                end
            end
            ST_XLATE: begin
                eng_req = 1'b1;
                if (eng_done) begin
                    ctl.push_rule = 1'b1;
                    if (adv >= {1'b0, len})
                        state_n = ST_EMIT;
                    else
                        pos_n = adv[POS_W-1:0];
                end
            end
            ST_EMIT: if (q_empty) begin
                ctl.clear = 1'b1;
                state_n   = ST_COLLECT;
            end
            default: state_n = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_COLLECT;
            pos      <= '0;
            overflow <= 1'b0;
        end else begin
            state    <= state_n;
            pos      <= pos_n;
            overflow <= ovf_n;
        end
    end

    assign accepting = (state == ST_COLLECT);
    assign emitting  = (state == ST_EMIT);

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        overflow |=> !overflow);  // R2
    AST_POS_IN_WORD: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> pos < len);   // R5

endmodule

// File: rtl/wordbuf_xlate_ctrl.sv
module wordbuf_xlate_ctrl
    import wbx_pkg::*;
#(
    parameter int MAX_CHARS = 40,
    parameter int QDEPTH    = 64,
    parameter int CPR       = 4,
    localparam int POS_W    = $clog2(MAX_CHARS + 1),
    localparam int CNT_W    = $clog2(QDEPTH + 1),
    localparam int NC_W     = $clog2(CPR + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CHAR_W-1:0]           rx_char,
    input  logic                        rx_strobe,
    output logic                        rx_accept,
    output logic                        eng_req,
    output logic [POS_W-1:0]            eng_pos,
    output logic [CHAR_W-1:0]           eng_entry,
    output logic [MAX_CHARS*CHAR_W-1:0] eng_word,
    output logic [POS_W-1:0]            eng_len,
    input  logic                        eng_done,
    input  logic [POS_W-1:0]            eng_consumed,
    input  logic [NC_W-1:0]             eng_ncodes,
    input  logic [CPR*CELL_W-1:0]       eng_codes,
    output logic                        out_valid,
    output logic [CELL_W-1:0]           out_cell,
    input  logic                        out_ready,
    output logic                        overflow
);

    wbx_ctl_t ctl;
    logic     q_empty, emitting, pop;

    wbx_sequencer #(.MAX_CHARS(MAX_CHARS), .POS_W(POS_W)) u_seq (
        .clk(clk), .rst(rst), .rx_strobe(rx_strobe), .rx_char(rx_char),
        .len(eng_len), .eng_done(eng_done), .eng_consumed(eng_consumed),
        .q_empty(q_empty), .ctl(ctl), .pos(eng_pos), .eng_req(eng_req),
        .accepting(rx_accept), .emitting(emitting), .overflow(overflow)
    );

    wbx_word_buf #(.MAX_CHARS(MAX_CHARS), .CHAR_W(CHAR_W), .POS_W(POS_W)) u_buf (
        .clk(clk), .rst(rst), .wr_en(ctl.buf_wr), .wr_char(rx_char),
        .clr(ctl.clear), .len(eng_len), .word(eng_word)
    );

    always_comb begin
        eng_entry = '0;
        for (int i = 0; i < MAX_CHARS; i++)
            if (eng_pos == POS_W'(i))
                eng_entry = eng_word[i*CHAR_W +: CHAR_W];
    end

    wbx_cell_queue #(.DEPTH(QDEPTH), .CELL_W(CELL_W), .CPR(CPR),
                     .CNT_W(CNT_W), .NC_W(NC_W)) u_q (
        .clk(clk), .rst(rst), .clr(ctl.clear),
        .push_en(ctl.push_space || ctl.push_rule),
        .push_n(ctl.push_space ? NC_W'(1) : eng_ncodes),
        .push_cells(ctl.push_space ? '0 : eng_codes),
        .pop(pop), .head(out_cell), .empty(q_empty)
    );

    assign out_valid = emitting && !q_empty;
    assign pop       = out_valid && out_ready;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_cell));  // R8

endmodule

// File: tb/wordbuf_xlate_ctrl_test.sv
module wordbuf_xlate_ctrl_test;

    localparam int MAXC = 40;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     rx_char = 8'h00;
    logic           rx_strobe = 1'b0;
    logic           rx_accept, eng_req, eng_done, out_valid, out_ready, overflow;
    logic [5:0]     eng_pos, eng_len, eng_consumed, out_cell;
    logic [7:0]     eng_entry;
    logic [MAXC*8-1:0] eng_word;
    logic [2:0]     eng_ncodes;
    logic [23:0]    eng_codes;

    int checks = 0, errors = 0, cycles = 0;
    int req_cycles = 0, ovf_cycles = 0;
    int pos_log [0:63];
    int pos_n = 0;
    int got [0:127];
    int got_n = 0;
    int exp_c [0:127];
    int exp_n = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wordbuf_xlate_ctrl uut (
        .clk(clk), .rst(rst), .rx_char(rx_char), .rx_strobe(rx_strobe),
        .rx_accept(rx_accept), .eng_req(eng_req), .eng_pos(eng_pos),
        .eng_entry(eng_entry), .eng_word(eng_word), .eng_len(eng_len),
        .eng_done(eng_done), .eng_consumed(eng_consumed),
        .eng_ncodes(eng_ncodes), .eng_codes(eng_codes),
        .out_valid(out_valid), .out_cell(out_cell), .out_ready(out_ready),
        .overflow(overflow)
    );

    // Engine model: "th" -> one cell using 2 chars, "x" -> two cells,
    // "0" -> reports 0 consumed, "z" -> consumes 5, else letter index.
    logic [7:0] m_next;
    always_comb begin
        m_next = 8'h00;
        for (int i = 0; i < MAXC; i++)
            if (i == int'(eng_pos) + 1 && i < int'(eng_len))
                m_next = eng_word[i*8 +: 8];
        eng_done     = eng_req;
        eng_consumed = 6'd1;
        eng_ncodes   = 3'd1;
        eng_codes    = '0;
        if (eng_entry == "t" && m_next == "h") begin
            eng_consumed = 6'd2; eng_codes[5:0] = 6'h39;
        end else if (eng_entry == "x") begin
            eng_ncodes = 3'd2; eng_codes[5:0] = 6'h3C; eng_codes[11:6] = 6'h18;
        end else if (eng_entry == "0") begin
            eng_consumed = 6'd0; eng_codes[5:0] = 6'h3F;
        end else if (eng_entry == "z") begin
            eng_consumed = 6'd5; eng_codes[5:0] = 6'h1A;
        end else begin
            eng_codes[5:0] = 6'(eng_entry - 8'h60);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor sampled away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && eng_req) begin
            req_cycles++;
            if (pos_n < 64) pos_log[pos_n] = int'(eng_pos);
            pos_n++;
            if (eng_entry != eng_word[int'(eng_pos)*8 +: 8]) begin
                checks++; errors++;
                $display("FAIL R4: entry actual=%0d expected=%0d",
                         eng_entry, eng_word[int'(eng_pos)*8 +: 8]);
            end
        end
        if (!rst && overflow) ovf_cycles++;
    end

    initial begin : watchdog
        wait (cycles > 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send_char(input byte c);
        rx_char = c; rx_strobe = 1'b1;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic send_word(input string s);
        for (int i = 0; i < s.len(); i++) send_char(s[i]);
    endtask

    task automatic drain();
        int guard = 0;
        got_n = 0;
        forever begin
            out_ready = 1'b1;
            if (out_valid) begin
                if (got_n < 128) got[got_n] = int'(out_cell);
                got_n++;
            end
            if (rx_accept && !out_valid) break;
            if (guard++ > 2000) break;
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    task automatic compare(input string req);
        int bad = -1;
        check(got_n == exp_n, {req, " cell count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (bad < 0 && got[i] != exp_c[i]) bad = i;
        if (bad >= 0) check(0, {req, " cell value"}, got[bad], exp_c[bad]);
        else          check(1, req, 0, 0);
        check(eng_len == 0 && rx_accept, {req, " back to collect R8"},
              int'(eng_len), 0);
    endtask

    task automatic t_reset();
        check(rx_accept == 1'b1, "R8 reset accept", int'(rx_accept), 1);
        check(out_valid == 1'b0 && eng_req == 1'b0 && overflow == 1'b0,
              "R8 reset idle", int'(out_valid), 0);
        check(eng_len == 0, "R1 reset len", int'(eng_len), 0);
    endtask

    task automatic t_simple();  // R1 R3 R6
        int r0 = req_cycles;
        send_word("cab");
        check(eng_len == 3, "R1 append", int'(eng_len), 3);
        check(eng_word[7:0] == "c" && eng_word[23:16] == "b", "R4 word layout",
              int'(eng_word[23:16]), int'("b"));
        send_char(" ");
        drain();
        exp_n = 3; exp_c[0] = 3; exp_c[1] = 1; exp_c[2] = 2;
        compare("R3 R6 simple word");
        check(req_cycles - r0 == 3, "R5 one rule per char", req_cycles - r0, 3);
    endtask

    task automatic t_skip();  // R5 R4
        int r0 = req_cycles;
        pos_n = 0;
        send_word("the ");
        drain();
        exp_n = 2; exp_c[0] = 'h39; exp_c[1] = 5;
        compare("R5 contraction");
        check(req_cycles - r0 == 2, "R5 skip count", req_cycles - r0, 2);
        check(pos_log[1] == 2, "R5 second entry position", pos_log[1], 2);
    endtask

    task automatic t_zero_and_overshoot();  // R5
        send_word("0a ");
        drain();
        exp_n = 2; exp_c[0] = 'h3F; exp_c[1] = 1;
        compare("R5 zero consumed");
        send_word("zb ");
        drain();
        exp_n = 1; exp_c[0] = 'h1A;
        compare("R5 overshoot end");
    endtask

    task automatic t_lone_space();  // R10
        int r0 = req_cycles;
        send_char(" ");
        drain();
        exp_n = 1; exp_c[0] = 0;
        compare("R10 lone space");
        check(req_cycles == r0, "R10 no engine request", req_cycles - r0, 0);
    endtask

    task automatic t_overflow();  // R2
        int o0 = ovf_cycles;
        for (int i = 0; i < 41; i++) send_char("b");
        drain();
        exp_n = 40;
        for (int i = 0; i < 40; i++) exp_c[i] = 2;
        compare("R2 overflow word");
        check(ovf_cycles - o0 == 1, "R2 overflow pulse", ovf_cycles - o0, 1);
    endtask

    task automatic t_queue_cap();  // R7 R6
        for (int i = 0; i < 40; i++) send_char("x");
        send_char(" ");
        drain();
        exp_n = 64;
        for (int i = 0; i < 64; i++) exp_c[i] = (i % 2 == 0) ? 'h3C : 'h18;
        compare("R7 queue capacity");
    endtask

    task automatic t_backpressure();  // R8 R9
        int wait_n = 0;
        send_word("cab ");
        while (!out_valid && wait_n < 200) begin @(negedge clk); wait_n++; end
        check(rx_accept == 1'b0, "R9 not accepting while draining",
              int'(rx_accept), 0);
        send_char("q");
        for (int i = 0; i < 8; i++) begin
            check(out_valid && out_cell == 6'd3, "R8 hold under stall",
                  int'(out_cell), 3);
            @(negedge clk);
        end
        drain();
        exp_n = 3; exp_c[0] = 3; exp_c[1] = 1; exp_c[2] = 2;
        compare("R8 stalled drain");
        send_word("b ");
        drain();
        exp_n = 1; exp_c[0] = 2;
        compare("R9 ignored strobe");
    endtask

    initial begin
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_simple();
        t_skip();
        t_zero_and_overshoot();
        t_lone_space();
        t_overflow();
        t_queue_cap();
        t_backpressure();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule